// File: doc/BRIEF.md
# Aligned Shift-Subtract Integer Remainder Unit

This block computes the unsigned remainder of a dividend `n` divided by a divisor `d`, both W bits wide. The quotient is not produced. When an operation starts, the divisor is shifted left so that its leading one sits in the same bit position as the leading one of the dividend. The shift distance comes from two leading-zero counts that are formed in the same cycle. After that, the unit runs one step per clock. Each step subtracts the aligned multiple from the running value only when that multiple fits, and then halves the multiple. The unit stops on the first step that leaves the running value below the divisor. The number of cycles therefore follows how far apart the operands are in magnitude, and it is not fixed at W.

An operation is launched by pulsing `start_i` with the operands while the unit is not busy. The result appears on `rem_o` together with a one-cycle `done_o` pulse. It stays there until the next operation finishes. A zero divisor is not computed: the unit reports it through `dz_err_o`, and the dividend is returned as the result.

Top module: `rem_unit`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `dz_err_o` are 0 and `rem_o` is 0.
- R2: A start is accepted only while `busy_o` is 0. A `start_i` pulse during an operation is ignored, and the running operation returns the remainder of its own operands.
- R3: For d ≠ 0, `rem_o` equals n mod d when `done_o` is high, and `dz_err_o` is 0. This includes operands with the top bit set.
- R4: If n < d, no step is run. `done_o` rises on the clock edge after the one that accepted the start, and `rem_o` equals n.
- R5: If d = 0, `done_o` rises on the clock edge after the one that accepted the start, with `dz_err_o` = 1 and `rem_o` = n.
- R6: The unit never needs more than W steps. `done_o` rises at most W+1 edges after the accepting edge. With n = all ones and d = 1 it takes exactly W+1.
- R7: Stepping stops as soon as the running value is below d. With n = 2^(W-1) and d = 1, `done_o` rises 2 edges after the accepting edge.
- R8: `done_o` is high for one cycle per operation. `rem_o` and `dz_err_o` keep their values until the next operation completes.
- R9: An operation with d ≠ 0 clears a `dz_err_o` left set by a previous zero-divisor operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch request, sampled while not busy |
| n_i | input | W | Dividend |
| d_i | input | W | Divisor |
| busy_o | output | 1 | A multi-step operation is in progress |
| done_o | output | 1 | One-cycle pulse: result valid |
| rem_o | output | W | Remainder, held until the next result |
| dz_err_o | output | 1 | Last operation had a zero divisor |

## Verification
The checker looks at every cycle and checks several properties. It checks that each non-error result is below the captured divisor and no larger than the captured dividend. It checks that an error flag appears only with a zero divisor. It checks that the result stays stable while the unit is idle and no start is given. It checks that an accepted start produces either a result or a busy cycle on the next edge. It also counts busy cycles and checks that the count never goes past W. The bench scenarios are needed for the rest. These are exact remainder values, the exact cycle count of the worst-case and early-stop operands, a start that is ignored while busy, and the error flag being cleared by a later operation.

// File: rtl/rem_pkg.sv
package rem_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } rem_state_e;
endpackage

// File: rtl/rem_lzc.sv
module rem_lzc #(
    parameter int W  = 32,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  val_i,
    output logic [CW-1:0] cnt_o
);
    always_comb begin
        cnt_o = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (val_i[i]) cnt_o = CW'(W - 1 - i);
        end
    end
endmodule

// File: rtl/rem_align.sv
module rem_align #(
    parameter int W = 32,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0] n_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] t_o,
    output logic         below_o,
    output logic         zero_o
);
    logic [CW-1:0] lz_n;
    logic [CW-1:0] lz_d;
    logic [CW-1:0] shamt;

    rem_lzc #(.W(W)) u_lz_n (.val_i(n_i), .cnt_o(lz_n));
    rem_lzc #(.W(W)) u_lz_d (.val_i(d_i), .cnt_o(lz_d));

    always_comb begin
        shamt   = (lz_d > lz_n) ? (lz_d - lz_n) : '0;
        t_o     = d_i << shamt;
        below_o = (n_i < d_i);
        zero_o  = (d_i == '0);
    end
endmodule

// File: rtl/rem_step.sv
module rem_step #(
    parameter int W = 32
) (
    input  logic [W-1:0] n_i,
    input  logic [W-1:0] t_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] n_o,
    output logic [W-1:0] t_o,
    output logic         fin_o
);
    logic         fits;
    logic [W-1:0] sub;

    always_comb begin
        fits  = (n_i >= t_i);
        sub   = {W{fits}} & t_i;
        n_o   = n_i - sub;
        t_o   = t_i >> 1;
        fin_o = (n_o < d_i);
    end
endmodule

// File: rtl/rem_unit.sv
module rem_unit #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [W-1:0] n_i,
    input  logic [W-1:0] d_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [W-1:0] rem_o,
    output logic         dz_err_o
);
    import rem_pkg::*;

    typedef struct packed {
        rem_state_e   st;
        logic [W-1:0] run;
        logic [W-1:0] mult;
        logic [W-1:0] dvs;
        logic [W-1:0] rem;
        logic         done;
        logic         err;
    } rem_regs_t;

    rem_regs_t s_d, s_q;

    logic [W-1:0] t_init;
    logic         op_below;
    logic         op_zero;
    logic [W-1:0] run_nx;
    logic [W-1:0] mult_nx;
    logic         step_fin;

    rem_align #(.W(W)) u_align (
        .n_i     (n_i),
        .d_i     (d_i),
        .t_o     (t_init),
        .below_o (op_below),
        .zero_o  (op_zero)
    );

    rem_step #(.W(W)) u_step (
        .n_i   (s_q.run),
        .t_i   (s_q.mult),
        .d_i   (s_q.dvs),
        .n_o   (run_nx),
        .t_o   (mult_nx),
        .fin_o (step_fin)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    if (op_zero) begin
                        s_d.rem  = n_i;
                        s_d.err  = 1'b1;
                        s_d.done = 1'b1;
                    end else if (op_below) begin
                        s_d.rem  = n_i;
                        s_d.err  = 1'b0;
                        s_d.done = 1'b1;
                    end else begin
                        s_d.run  = n_i;
                        s_d.mult = t_init;
                        s_d.dvs  = d_i;
                        s_d.err  = 1'b0;
                        s_d.st   = ST_RUN;
                    end
                end
            end
            ST_RUN: begin
                s_d.run  = run_nx;
                s_d.mult = mult_nx;
                if (step_fin) begin
                    s_d.rem  = run_nx;
                    s_d.done = 1'b1;
                    s_d.st   = ST_IDLE;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, run: '0, mult: '0, dvs: '0,
                     rem: '0, done: 1'b0, err: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o   = (s_q.st == ST_RUN);
    assign done_o   = s_q.done;
    assign rem_o    = s_q.rem;
    assign dz_err_o = s_q.err;
endmodule

// File: rtl/rem_unit_chk.sv
module rem_unit_chk #(
    parameter int W = 32,
    localparam int KW = $clog2(W + 2) + 1
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start_i,
    input logic [W-1:0] n_i,
    input logic [W-1:0] d_i,
    input logic         busy_o,
    input logic         done_o,
    input logic [W-1:0] rem_o,
    input logic         dz_err_o
);
    logic [W-1:0]  n_cap;
    logic [W-1:0]  d_cap;
    logic [KW-1:0] busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            n_cap    <= '0;
            d_cap    <= '0;
            busy_cnt <= '0;
        end else begin
            if (start_i && !busy_o) begin
                n_cap <= n_i;
                d_cap <= d_i;
            end
            busy_cnt <= busy_o ? busy_cnt + 1'b1 : '0;
        end
    end

    // R3: a valid remainder is below the divisor
    p_rem_below_d_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !dz_err_o) |-> (rem_o < d_cap));

    // R3: a remainder never exceeds the dividend
    p_rem_le_n_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (rem_o <= n_cap));

    // R5: the error flag comes only with a zero divisor
    p_err_zero_d_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && dz_err_o) |-> (d_cap == '0 && rem_o == n_cap));

    // R8: the result is held while idle without a start
    p_rem_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(rem_o) && $stable(dz_err_o) && !done_o));

    // R2: an accepted start leads to a result or a running step
    p_start_acts_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (done_o || busy_o));

    // R6: stepping never takes more than W cycles
    p_step_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_cnt <= KW'(W));
endmodule

bind rem_unit rem_unit_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .n_i      (n_i),
    .d_i      (d_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .rem_o    (rem_o),
    .dz_err_o (dz_err_o)
);

// File: tb/tb_rem_unit.sv
module tb_rem_unit;
    localparam int W  = 32;
    localparam int NV = 12;

    localparam logic [W-1:0] VN [NV] = '{
        32'd100, 32'd7, 32'd0, 32'd12345, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
        32'h8000_0001, 32'hDEAD_BEEF, 32'hFFFF_FFFF, 32'd15, 32'd1000000, 32'h0000_0001
    };
    localparam logic [W-1:0] VD [NV] = '{
        32'd7, 32'd100, 32'd5, 32'd0, 32'd1, 32'hFFFF_FFFF,
        32'h8000_0000, 32'd1234, 32'h8000_0001, 32'd6, 32'd3, 32'h0000_0001
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [W-1:0] n_i = '0;
    logic [W-1:0] d_i = '0;
    logic         busy_o, done_o, dz_err_o;
    logic [W-1:0] rem_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    rem_unit #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .n_i(n_i), .d_i(d_i),
        .busy_o(busy_o), .done_o(done_o), .rem_o(rem_o), .dz_err_o(dz_err_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input logic [W-1:0] n, input logic [W-1:0] d,
                          output int lat);
        @(negedge clk);
        n_i = n; d_i = d; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat = 1;
        while (!done_o && lat < 200) begin
            @(negedge clk);
            lat++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int lat;
        logic [W-1:0] exp;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy_o && !done_o && !dz_err_o, "R1", "status after reset",
            {29'd0, busy_o, done_o, dz_err_o}, '0);
        chk(rem_o == '0, "R1", "rem after reset", rem_o, '0);
        rst_n = 1'b1;

        // Vector table: R3, R4, R5, R6
        for (int i = 0; i < NV; i++) begin
            exp = (VD[i] == '0) ? VN[i] : (VN[i] % VD[i]);
            run_op(VN[i], VD[i], lat);
            chk(done_o, "R3", "done seen", {31'd0, done_o}, 1);
            chk(rem_o == exp, (VD[i] == '0) ? "R5" : "R3", "remainder", rem_o, exp);
            chk(dz_err_o == (VD[i] == '0), "R5", "zero-divisor flag",
                {31'd0, dz_err_o}, {31'd0, VD[i] == '0});
            chk(lat <= W + 1, "R6", "latency bound", lat, W + 1);
            if (VD[i] == '0 || VN[i] < VD[i])
                chk(lat == 1, (VD[i] == '0) ? "R5" : "R4", "single-cycle latency", lat, 1);
        end

        // R6 worst case exact
        run_op(32'hFFFF_FFFF, 32'd1, lat);
        chk(lat == W + 1 && rem_o == '0, "R6", "worst-case latency", lat, W + 1);

        // R7 early stop
        run_op(32'h8000_0000, 32'd1, lat);
        chk(lat == 2 && rem_o == '0, "R7", "early-stop latency", lat, 2);

        // R8 pulse and hold
        run_op(32'd1000, 32'd7, lat);
        chk(rem_o == 32'd6, "R3", "1000 mod 7", rem_o, 32'd6);
        @(negedge clk);
        chk(!done_o, "R8", "done is one cycle", {31'd0, done_o}, 0);
        n_i = 32'd55; d_i = 32'd9;
        repeat (5) @(negedge clk);
        chk(rem_o == 32'd6 && !done_o, "R8", "result held while idle", rem_o, 32'd6);

        // R2 start ignored while busy
        @(negedge clk);
        n_i = 32'hFFFF_FFFF; d_i = 32'd1; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (3) @(negedge clk);
        n_i = 32'd7; d_i = 32'd3; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o, "R2", "still busy after ignored start", {31'd0, busy_o}, 1);
        lat = 0;
        while (!done_o && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        chk(rem_o == '0 && !dz_err_o, "R2", "first operands kept", rem_o, '0);

        // R9 error cleared by a later operation
        run_op(32'd77, 32'd0, lat);
        chk(dz_err_o && rem_o == 32'd77, "R5", "zero divisor", rem_o, 32'd77);
        @(negedge clk);
        chk(dz_err_o, "R8", "error flag held", {31'd0, dz_err_o}, 1);
        run_op(32'd77, 32'd10, lat);
        chk(!dz_err_o && rem_o == 32'd7, "R9", "flag cleared", {31'd0, dz_err_o}, 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule